// File: doc/BRIEF.md
# Series Verdict Checker for Tagged Measurement Records

This block checks a stream of hit measurement records against expected values. Each record carries a tag plus five measured quantities: duration, energy, counts, risetime and amplitude. Two special tag values act as markers. One starts a test series and the other ends it. Between the markers, every other tag names a test pattern. The tag also selects a row of expected values in a small table. The table is written through a simple write port before the run.

Two records in a row that carry the same tag are treated as noise followed by a replacement, so only the last of them is evaluated. When the first pattern of a series is evaluated, its measured-minus-expected error for duration, energy and counts is stored as an offset. That offset is removed from every pattern of the series. Each evaluated pattern produces a one-cycle result pulse with five violation flags. When a series closes, a one-cycle verdict pulse says whether the whole series passed.

Percentage deviations are computed by one shared sequential divider. The block reports `busy` while a pattern is under evaluation, and a new record may only be presented when `busy` is low.

Top module: `series_verdict_checker`

## Requirements
- R1: After reset, `busy`, `patValid`, `verdictValid` and `errSticky` are all 0.
- R2: While `tblWe` is high, `tblData` is stored in row `tblRow` at field `tblField`, with the fields coded 0 duration, 1 energy, 2 counts, 3 risetime, 4 amplitude. Writing any field marks that row as loaded. A pattern tag T uses row (T-70)/2 when T is even and 70 <= T < 70+2*DEPTH.
- R3: Tag 18 opens a series and tag 2 closes it. After the close, `verdictValid` pulses for exactly one cycle, following the result of the last pending pattern. `verdictPass` is 1 only if no pattern of the series raised a flag and the series correction was valid.
- R4: When consecutive records in an open series share a tag, each one replaces the previous one. Only the last one is evaluated, and it gives exactly one `patValid` pulse.
- R5: The first pattern of a series that hits a loaded row stores (measured - expected) for duration, energy and counts as the series offsets. Every pattern of the series subtracts these offsets before comparison, so the first pattern always passes those three checks.
- R6: Duration, energy and counts are each flagged when trunc(|measured - offset - expected| * 100 / expected) > 5. An expected value of 0 is always flagged.
- R7: Risetime uses no offset. It is flagged when trunc(|measured - expected| * 100 / expected) > 10.
- R8: Amplitude is in 0.1 dB units. It is flagged when |measured - expected - correction| > 10, where the correction is `ampCorr` sampled at the opening marker.
- R9: On a result pulse, `patTag` is the evaluated tag. `patFlags` bit 0 is duration, bit 1 energy, bit 2 counts, bit 3 risetime and bit 4 amplitude, with 1 meaning a violation.
- R10: A closing marker with no open series sets `errSticky` and produces no pulse. A pattern tag that maps to no loaded row sets `errSticky`, reports `patFlags` = 5'b11111 and fails the series.
- R11: A record with a non-marker tag while no series is open produces no output.
- R12: A correction outside -5..+5 (±0.5 dB) at the opening marker fails the series verdict even when every pattern passes.
- R13: `errSticky` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tblWe | input | 1 | Expected-value table write enable |
| tblRow | input | RW | Table row to write |
| tblField | input | 3 | Field code to write (see R2) |
| tblData | input | VW | Expected value to store |
| ampCorr | input | CW | Signed amplitude correction, 0.1 dB units |
| recValid | input | 1 | Record present (only honoured while `busy` is low) |
| recTag | input | TW | Record tag |
| recDur | input | VW | Measured duration |
| recEny | input | VW | Measured energy |
| recCnt | input | VW | Measured counts |
| recRise | input | VW | Measured risetime |
| recAmp | input | VW | Measured amplitude, 0.1 dB units |
| busy | output | 1 | Evaluation in progress |
| patValid | output | 1 | One-cycle pattern result pulse |
| patTag | output | TW | Tag of the evaluated pattern |
| patFlags | output | 5 | Violation flags (see R9) |
| verdictValid | output | 1 | One-cycle series verdict pulse |
| verdictPass | output | 1 | Series verdict, 1 = pass |
| errSticky | output | 1 | Sticky protocol or table-miss error |

## Verification
The hardest state to reach is a series in which the offset from the first pattern, the replacement of a noise hit and exact tolerance boundaries all meet. In that state the verdict depends on which record was kept and on which offsets were latched. To reach it, the stimulus opens series whose first pattern deviates on purpose. It sends a bad noise record followed by a good record with the same tag. It then places later patterns exactly on and just past the 5 %, 10 % and 1 dB limits, with the limits computed after the offsets are removed. Table misses are forced with an odd tag and with an in-range row that was never loaded. Both are placed ahead of the first valid pattern, so they must not capture the offsets.

// File: rtl/svc_pkg.sv
package svc_pkg;
  localparam int NPAR   = 5;
  localparam int F_DUR  = 0;
  localparam int F_ENY  = 1;
  localparam int F_CNT  = 2;
  localparam int F_RISE = 3;
  localparam int F_AMP  = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic       clrSeries;
    logic       loadPend;
    logic       copyEval;
    logic       setOffset;
    logic       markMiss;
    logic       divStart;
    logic       paramDone;
    logic       emitPat;
    logic       emitVerdict;
    logic [1:0] paramSel;
  } strobe_t;
endpackage

// File: rtl/svc_divider.sv
module svc_divider #(
  parameter int NW = 26,
  parameter int DW = 16,
  localparam int LW = $clog2(NW + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [NW-1:0] quot
);
  logic [DW:0]   rem;
  logic [DW:0]   trial;
  logic [LW-1:0] left;

  assign trial = {rem[DW-1:0], quot[NW-1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rem  <= '0;
      quot <= '0;
      left <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem  <= '0;
        quot <= dividend;
        left <= LW'(NW);
      end else if (left != '0) begin
        if (trial >= {1'b0, divisor}) begin
          rem  <= trial - {1'b0, divisor};
          quot <= {quot[NW-2:0], 1'b1};
        end else begin
          rem  <= trial;
          quot <= {quot[NW-2:0], 1'b0};
        end
        left <= left - 1'b1;
        if (left == LW'(1)) done <= 1'b1;
      end
    end
  end

  // R6: a new division never starts while one is still running
  assert_start_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    start |-> (left == '0));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/svc_ctrl.sv
module svc_ctrl import svc_pkg::*; #(
  parameter int TW        = 8,
  parameter int OPEN_TAG  = 18,
  parameter int CLOSE_TAG = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          recValid,
  input  logic [TW-1:0] recTag,
  input  logic          tagSame,
  input  logic          idxOk,
  input  logic          divDone,
  output strobe_t       st,
  output logic          busy,
  output logic          errSticky
);
  typedef enum logic [2:0] {IDLE, LOOKUP, DIV_GO, DIV_WAIT, EMIT, VERDICT} state_t;
  state_t     state;
  logic       seriesOpen, pendValid, closeAfter, firstPend;
  logic [1:0] paramSel;
  logic       accept, isOpen, isClose, patRec, retire, closeEmpty, orphan;

  assign accept     = (state == IDLE) && recValid;
  assign isOpen     = recTag == TW'(OPEN_TAG);
  assign isClose    = recTag == TW'(CLOSE_TAG);
  assign patRec     = accept && !isOpen && !isClose && seriesOpen;
  assign retire     = (patRec && pendValid && !tagSame) ||
                      (accept && isClose && seriesOpen && pendValid);
  assign closeEmpty = accept && isClose && seriesOpen && !pendValid;
  assign orphan     = accept && isClose && !seriesOpen;
  assign busy       = state != IDLE;

  always_comb begin
    st             = '0;
    st.clrSeries   = accept && isOpen;
    st.loadPend    = patRec;
    st.copyEval    = retire;
    st.setOffset   = (state == LOOKUP) && idxOk && firstPend;
    st.markMiss    = (state == LOOKUP) && !idxOk;
    st.divStart    = state == DIV_GO;
    st.paramDone   = (state == DIV_WAIT) && divDone;
    st.emitPat     = state == EMIT;
    st.emitVerdict = state == VERDICT;
    st.paramSel    = paramSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= IDLE;
      seriesOpen <= 1'b0;
      pendValid  <= 1'b0;
      closeAfter <= 1'b0;
      firstPend  <= 1'b0;
      paramSel   <= '0;
      errSticky  <= 1'b0;
    end else begin
      case (state)
        IDLE: begin
          if (st.clrSeries) begin
            seriesOpen <= 1'b1;
            firstPend  <= 1'b1;
            pendValid  <= 1'b0;
          end
          if (patRec) pendValid <= 1'b1;
          if (orphan) errSticky <= 1'b1;
          if (retire) begin
            closeAfter <= isClose;
            if (isClose) pendValid <= 1'b0;
            state <= LOOKUP;
          end else if (closeEmpty) begin
            state <= VERDICT;
          end
        end
        LOOKUP: begin
          paramSel <= '0;
          if (!idxOk) begin
            errSticky <= 1'b1;
            state     <= EMIT;
          end else begin
            if (firstPend) firstPend <= 1'b0;
            state <= DIV_GO;
          end
        end
        DIV_GO: state <= DIV_WAIT;
        DIV_WAIT: if (divDone) begin
          if (paramSel == 2'd3) state <= EMIT;
          else begin
            paramSel <= paramSel + 1'b1;
            state    <= DIV_GO;
          end
        end
        EMIT: state <= closeAfter ? VERDICT : IDLE;
        VERDICT: begin
          seriesOpen <= 1'b0;
          state      <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  // R3: a verdict is only issued for a series that was opened
  assert_verdict_needs_series_R3: assert property (@(posedge clk) disable iff (!rstN)
    st.emitVerdict |-> seriesOpen);
  // R13: the error flag never clears once set
  assert_err_sticky_R13: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);
  // R5: offsets are captured at most once per series
  assert_single_offset_R5: assert property (@(posedge clk) disable iff (!rstN)
    st.setOffset |=> !firstPend);
endmodule

// File: rtl/svc_datapath.sv
module svc_datapath import svc_pkg::*; #(
  parameter int VW        = 16,
  parameter int TW        = 8,
  parameter int CW        = 8,
  parameter int DEPTH     = 9,
  parameter int BASE_TAG  = 70,
  parameter int PCT_TOL   = 5,
  parameter int RISE_TOL  = 10,
  parameter int AMP_TOL   = 10,
  parameter int CORR_MAX  = 5,
  localparam int RW = $clog2(DEPTH),
  localparam int NW = VW + 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              st,
  input  logic                 tblWe,
  input  logic [RW-1:0]        tblRow,
  input  logic [2:0]           tblField,
  input  logic [VW-1:0]        tblData,
  input  logic signed [CW-1:0] ampCorr,
  input  logic [TW-1:0]        recTag,
  input  logic [VW-1:0]        recVals [NPAR],
  output logic                 tagSame,
  output logic                 idxOk,
  output logic                 divDone,
  output logic                 patValid,
  output logic [TW-1:0]        patTag,
  output logic [NPAR-1:0]      patFlags,
  output logic                 verdictValid,
  output logic                 verdictPass
);
  logic [VW-1:0]        expTab [DEPTH][NPAR];
  logic [DEPTH-1:0]     rowOk;
  logic [TW-1:0]        pendTag, evalTag;
  logic [VW-1:0]        pendVals [NPAR];
  logic [VW-1:0]        evalVals [NPAR];
  logic signed [VW:0]   off [4];
  logic signed [CW-1:0] corrReg;
  logic                 seriesFail, missR;
  logic [3:0]           flagAcc;

  // table write port
  always_ff @(posedge clk) begin
    if (tblWe && int'(tblRow) < DEPTH && int'(tblField) < NPAR)
      expTab[tblRow][tblField] <= tblData;
  end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rowOk <= '0;
    else if (tblWe && int'(tblRow) < DEPTH) rowOk[tblRow] <= 1'b1;
  end

  // row lookup from the tag under evaluation
  logic [TW-1:0] relTag;
  logic [RW-1:0] rowIdx;
  logic          inRange;
  assign relTag  = evalTag - TW'(BASE_TAG);
  assign rowIdx  = relTag[RW:1];
  assign inRange = (evalTag >= TW'(BASE_TAG)) && !relTag[0] &&
                   (int'(relTag[TW-1:1]) < DEPTH);
  assign idxOk   = inRange && rowOk[rowIdx];
  assign tagSame = pendTag == recTag;

  // percentage path for the selected parameter
  logic [VW-1:0]        expSel, measSel;
  logic signed [VW:0]   offSel;
  logic signed [VW+2:0] diff;
  logic [VW+2:0]        absDiff;
  logic [NW-1:0]        dividend, quot;
  int                   tolSel;
  assign expSel   = expTab[rowIdx][st.paramSel];
  assign measSel  = evalVals[st.paramSel];
  assign offSel   = off[st.paramSel];
  assign diff     = $signed({3'b000, measSel}) - $signed({3'b000, expSel})
                  - $signed({{2{offSel[VW]}}, offSel});
  assign absDiff  = diff[VW+2] ? (VW+3)'(-diff) : diff;
  assign dividend = NW'(absDiff) * NW'(100);
  assign tolSel   = (st.paramSel == 2'd3) ? RISE_TOL : PCT_TOL;

  svc_divider #(.NW(NW), .DW(VW)) u_div (
    .clk(clk), .rstN(rstN), .start(st.divStart), .dividend(dividend),
    .divisor(expSel), .done(divDone), .quot(quot)
  );

  // amplitude path in 0.1 dB
  logic signed [VW+1:0] ampDiff;
  logic                 ampFail, corrBad;
  assign ampDiff = $signed({2'b00, evalVals[F_AMP]}) - $signed({2'b00, expTab[rowIdx][F_AMP]})
                 - $signed({{(VW+2-CW){corrReg[CW-1]}}, corrReg});
  assign ampFail = (ampDiff > AMP_TOL) || (ampDiff < -AMP_TOL);
  assign corrBad = (ampCorr > CORR_MAX) || (ampCorr < -CORR_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendTag      <= '0;
      evalTag      <= '0;
      corrReg      <= '0;
      seriesFail   <= 1'b0;
      missR        <= 1'b0;
      flagAcc      <= '0;
      patValid     <= 1'b0;
      patTag       <= '0;
      patFlags     <= '0;
      verdictValid <= 1'b0;
      verdictPass  <= 1'b0;
      for (int k = 0; k < 4; k++) off[k] <= '0;
      for (int k = 0; k < NPAR; k++) begin
        pendVals[k] <= '0;
        evalVals[k] <= '0;
      end
    end else begin
      patValid     <= 1'b0;
      verdictValid <= 1'b0;
      if (st.clrSeries) begin
        corrReg    <= ampCorr;
        seriesFail <= corrBad;
        for (int k = 0; k < 4; k++) off[k] <= '0;
      end
      if (st.copyEval) begin
        evalTag <= pendTag;
        missR   <= 1'b0;
        flagAcc <= '0;
        for (int k = 0; k < NPAR; k++) evalVals[k] <= pendVals[k];
      end
      if (st.loadPend) begin
        pendTag <= recTag;
        for (int k = 0; k < NPAR; k++) pendVals[k] <= recVals[k];
      end
      if (st.setOffset)
        for (int k = 0; k < 3; k++)
          off[k] <= $signed({1'b0, evalVals[k]}) - $signed({1'b0, expTab[rowIdx][k]});
      if (st.markMiss) missR <= 1'b1;
      if (st.paramDone) flagAcc[st.paramSel] <= quot > NW'(tolSel);
      if (st.emitPat) begin
        patValid   <= 1'b1;
        patTag     <= evalTag;
        patFlags   <= missR ? '1 : {ampFail, flagAcc};
        if (missR || ampFail || (flagAcc != '0)) seriesFail <= 1'b1;
      end
      if (st.emitVerdict) begin
        verdictValid <= 1'b1;
        verdictPass  <= !seriesFail;
      end
    end
  end

  // R3: verdict is a single-cycle pulse
  assert_verdict_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    verdictValid |=> !verdictValid);
  // R9: pattern results and verdicts never share a cycle
  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(patValid && verdictValid));
  // R10: a table miss reports every flag
  assert_miss_flags_R10: assert property (@(posedge clk) disable iff (!rstN)
    (st.emitPat && missR) |=> (patFlags == '1));
endmodule

// File: rtl/series_verdict_checker.sv
module series_verdict_checker import svc_pkg::*; #(
  parameter int VW        = 16,
  parameter int TW        = 8,
  parameter int CW        = 8,
  parameter int DEPTH     = 9,
  parameter int OPEN_TAG  = 18,
  parameter int CLOSE_TAG = 2,
  parameter int BASE_TAG  = 70,
  parameter int PCT_TOL   = 5,
  parameter int RISE_TOL  = 10,
  parameter int AMP_TOL   = 10,
  parameter int CORR_MAX  = 5,
  localparam int RW = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tblWe,
  input  logic [RW-1:0]        tblRow,
  input  logic [2:0]           tblField,
  input  logic [VW-1:0]        tblData,
  input  logic signed [CW-1:0] ampCorr,
  input  logic                 recValid,
  input  logic [TW-1:0]        recTag,
  input  logic [VW-1:0]        recDur,
  input  logic [VW-1:0]        recEny,
  input  logic [VW-1:0]        recCnt,
  input  logic [VW-1:0]        recRise,
  input  logic [VW-1:0]        recAmp,
  output logic                 busy,
  output logic                 patValid,
  output logic [TW-1:0]        patTag,
  output logic [NPAR-1:0]      patFlags,
  output logic                 verdictValid,
  output logic                 verdictPass,
  output logic                 errSticky
);
  strobe_t       st;
  logic          tagSame, idxOk, divDone;
  logic [VW-1:0] recVals [NPAR];

  assign recVals[F_DUR]  = recDur;
  assign recVals[F_ENY]  = recEny;
  assign recVals[F_CNT]  = recCnt;
  assign recVals[F_RISE] = recRise;
  assign recVals[F_AMP]  = recAmp;

  svc_ctrl #(.TW(TW), .OPEN_TAG(OPEN_TAG), .CLOSE_TAG(CLOSE_TAG)) u_ctrl (
    .clk(clk), .rstN(rstN), .recValid(recValid), .recTag(recTag),
    .tagSame(tagSame), .idxOk(idxOk), .divDone(divDone),
    .st(st), .busy(busy), .errSticky(errSticky)
  );

  svc_datapath #(
    .VW(VW), .TW(TW), .CW(CW), .DEPTH(DEPTH), .BASE_TAG(BASE_TAG),
    .PCT_TOL(PCT_TOL), .RISE_TOL(RISE_TOL), .AMP_TOL(AMP_TOL), .CORR_MAX(CORR_MAX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .tblWe(tblWe), .tblRow(tblRow),
    .tblField(tblField), .tblData(tblData), .ampCorr(ampCorr), .recTag(recTag),
    .recVals(recVals), .tagSame(tagSame), .idxOk(idxOk), .divDone(divDone),
    .patValid(patValid), .patTag(patTag), .patFlags(patFlags),
    .verdictValid(verdictValid), .verdictPass(verdictPass)
  );
endmodule

// File: tb/series_verdict_checker_bench.sv
module series_verdict_checker_bench;
  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tblWe = 1'b0;
  logic [3:0]        tblRow = '0;
  logic [2:0]        tblField = '0;
  logic [15:0]       tblData = '0;
  logic signed [7:0] ampCorr = '0;
  logic              recValid = 1'b0;
  logic [7:0]        recTag = '0;
  logic [15:0]       recDur = '0, recEny = '0, recCnt = '0, recRise = '0, recAmp = '0;
  logic              busy, patValid, verdictValid, verdictPass, errSticky;
  logic [7:0]        patTag;
  logic [4:0]        patFlags;

  always #10 clk = ~clk; // 50 MHz

  series_verdict_checker u_series_verdict_checker (
    .clk(clk), .rstN(rstN), .tblWe(tblWe), .tblRow(tblRow), .tblField(tblField),
    .tblData(tblData), .ampCorr(ampCorr), .recValid(recValid), .recTag(recTag),
    .recDur(recDur), .recEny(recEny), .recCnt(recCnt), .recRise(recRise),
    .recAmp(recAmp), .busy(busy), .patValid(patValid), .patTag(patTag),
    .patFlags(patFlags), .verdictValid(verdictValid), .verdictPass(verdictPass),
    .errSticky(errSticky)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    int    kind; // 0 pattern, 1 verdict
    int    tag;
    int    val;
    string req;
  } item_t;
  item_t sb[$];

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model state
  int mOff[3];
  int mFirst = 0;
  int mCorr = 0;
  int mFail = 0;

  function automatic int expv(int row, int f);
    case (f)
      0: return 100 * (row + 1);
      1: return 500 + 50 * row;
      2: return 20 + 10 * row;
      3: return 90 + row;
      default: return 600 + 20 * row;
    endcase
  endfunction

  function automatic int pct(int d, int e);
    if (e == 0) return 1 << 30;
    return ((d < 0 ? -d : d) * 100) / e;
  endfunction

  task automatic loadTable();
    for (int r = 0; r < 8; r++)
      for (int f = 0; f < 5; f++) begin
        @(negedge clk);
        tblWe = 1'b1; tblRow = 4'(r); tblField = 3'(f); tblData = 16'(expv(r, f));
      end
    @(negedge clk);
    tblWe = 1'b0;
  endtask

  task automatic sendRec(int tag, int d, int e, int c, int r, int a);
    @(negedge clk);
    while (busy) @(negedge clk);
    recValid = 1'b1; recTag = 8'(tag);
    recDur = 16'(d); recEny = 16'(e); recCnt = 16'(c); recRise = 16'(r); recAmp = 16'(a);
    @(negedge clk);
    recValid = 1'b0;
  endtask

  task automatic openSeries(int corr);
    ampCorr = 8'(corr);
    mCorr  = corr;
    mFirst = 1;
    mFail  = (corr > 5 || corr < -5) ? 1 : 0;
    sendRec(18, 0, 0, 0, 0, 0);
  endtask

  // driver side of the scoreboard: predict one pattern result
  task automatic expectPat(string req, int tag, int d, int e, int c, int r, int a);
    item_t it;
    int row, flags, ad;
    row = (tag - 70) / 2;
    if (tag < 70 || (tag % 2) != 0 || row >= 8) begin
      flags = 31;
      mFail = 1;
    end else begin
      if (mFirst != 0) begin
        mOff[0] = d - expv(row, 0);
        mOff[1] = e - expv(row, 1);
        mOff[2] = c - expv(row, 2);
        mFirst  = 0;
      end
      flags = 0;
      if (pct(d - mOff[0] - expv(row, 0), expv(row, 0)) > 5) flags |= 1;
      if (pct(e - mOff[1] - expv(row, 1), expv(row, 1)) > 5) flags |= 2;
      if (pct(c - mOff[2] - expv(row, 2), expv(row, 2)) > 5) flags |= 4;
      if (pct(r - expv(row, 3), expv(row, 3)) > 10) flags |= 8;
      ad = a - expv(row, 4) - mCorr;
      if (ad > 10 || ad < -10) flags |= 16;
      if (flags != 0) mFail = 1;
    end
    it.kind = 0; it.tag = tag; it.val = flags; it.req = req;
    sb.push_back(it);
  endtask

  task automatic expectVerdict(string req);
    item_t it;
    it.kind = 1; it.tag = 0; it.val = (mFail == 0) ? 1 : 0; it.req = req;
    sb.push_back(it);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rstN && (patValid || verdictValid)) begin
      if (sb.size() == 0) begin
        check("R11", "unexpected output pulse", 1, 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (patValid) begin
          check(it.req, "kind(pattern)", 0, it.kind);
          check(it.req, "patTag", int'(patTag), it.tag);
          check(it.req, "patFlags", int'(patFlags), it.val);
        end else begin
          check(it.req, "kind(verdict)", 1, it.kind);
          check(it.req, "verdictPass", int'(verdictPass), it.val);
        end
      end
    end
  end

  task automatic drain();
    int n = 0;
    while (sb.size() != 0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check("R3", "scoreboard drained", sb.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", "busy", int'(busy), 0);
    check("R1", "patValid", int'(patValid), 0);
    check("R1", "verdictValid", int'(verdictValid), 0);
    check("R1", "errSticky", int'(errSticky), 0);
    rstN = 1'b1;
    loadTable(); // R2

    // R11: a pattern with no open series produces nothing
    sendRec(70, 100, 500, 20, 90, 600);
    repeat (300) @(negedge clk);
    check("R11", "output with no series", sb.size(), 0);

    // Series A: offsets from the first pattern, noise replacement, boundaries
    openSeries(0);
    sendRec(70, 110, 520, 21, 90, 600);
    expectPat("R5 R2", 70, 110, 520, 21, 90, 600);
    sendRec(72, 50, 100, 3, 10, 300);          // noise hit, replaced (R4)
    sendRec(72, 210, 570, 31, 95, 625);
    expectPat("R4 R7", 72, 210, 570, 31, 95, 625);
    sendRec(74, 330, 620, 43, 102, 651);       // R6 R7 boundaries, R8 over
    expectPat("R6 R8 R9", 74, 330, 620, 43, 102, 651);
    expectVerdict("R3");
    sendRec(2, 0, 0, 0, 0, 0);
    drain();

    // Series B: correction +3, everything on the limits, verdict pass
    openSeries(3);
    sendRec(70, 105, 540, 22, 95, 603);
    expectPat("R5", 70, 105, 540, 22, 95, 603);
    sendRec(76, 405, 690, 52, 99, 668);
    expectPat("R8", 76, 405, 690, 52, 99, 668);
    sendRec(78, 530, 700, 62, 84, 693);
    expectPat("R6 R7 R8", 78, 530, 700, 62, 84, 693);
    expectVerdict("R3");
    sendRec(2, 0, 0, 0, 0, 0);
    drain();

    // Series C: correction out of range fails the verdict
    openSeries(7);
    sendRec(70, 100, 500, 20, 90, 607);
    expectPat("R12", 70, 100, 500, 20, 90, 607);
    expectVerdict("R12");
    sendRec(2, 0, 0, 0, 0, 0);
    drain();

    // Empty series passes
    openSeries(0);
    expectVerdict("R3");
    sendRec(2, 0, 0, 0, 0, 0);
    drain();

    // R10: close with no series sets the sticky error and nothing else
    check("R10", "errSticky before orphan close", int'(errSticky), 0);
    sendRec(2, 0, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    check("R10", "errSticky after orphan close", int'(errSticky), 1);

    // R10: table misses (odd tag, unloaded row) ahead of the first hit
    openSeries(0);
    sendRec(71, 100, 500, 20, 90, 600);
    expectPat("R10", 71, 100, 500, 20, 90, 600);
    sendRec(86, 100, 500, 20, 90, 600);
    expectPat("R10", 86, 100, 500, 20, 90, 600);
    sendRec(70, 130, 480, 25, 92, 605);
    expectPat("R5 R10", 70, 130, 480, 25, 92, 605);
    expectVerdict("R10");
    sendRec(2, 0, 0, 0, 0, 0);
    drain();

    repeat (10) @(negedge clk);
    check("R13", "errSticky held", int'(errSticky), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R3 actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule